// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a bank of performance event counters next to one free-running cycle counter. Each general counter is 32 bits wide. It adds one whenever the event its type selector picks fires, provided the bank and that counter are both enabled. A software increment mask can bump counters set to the software type in the same way.

Counters are paired as (0,1), (2,3) and so on. When the even member of a pair wraps, it raises its own overflow flag. In the same cycle it hands a chain event to its odd partner, which counts that event only if it is enabled and typed for chaining. The two halves stay separate registers, and each one reports its own overflow.

The cycle counter is 64 bits wide. A mode input chooses whether its overflow is taken on the carry out of bit 63 or out of bit 31. One read/write port reaches every counter. Overflow flags are sticky until they are cleared, and a masked OR of those flags drives the interrupt request.

Top module: `chain_cnt_bank`

## Requirements
- R1: A general counter whose type code is k, with 1 <= k <= NUM_EVT, adds one on each cycle in which event strobe bit k-1 is high, while both the global enable and its own enable bit are set.
- R2: While the global enable is low, no counter changes, including the cycle counter, whatever strobes or software increments arrive.
- R3: A counter whose enable bit is low ignores hardware events and software increments. Enable bit NUM_CNT belongs to the cycle counter.
- R4: A counter typed 0x00 (software increment) adds one in each cycle in which its bit of the software increment mask is high. It does not respond to event strobes.
- R5: A general counter that wraps from 0xFFFFFFFF to zero sets its overflow flag in that cycle. A flag stays set until a one is written to its bit of the clear input. When set and clear coincide, set wins.
- R6: When an even counter i, with i+1 < NUM_CNT, wraps, counter i+1 adds one in the same cycle only if it is enabled and typed 0x1E (chain). A counter of any other type, or a disabled one, does not take the chain event.
- R7: The last even counter, whose partner index would be the cycle counter, never chains. Its wrap sets only its own flag, and the cycle counter advances by exactly its usual one.
- R8: When both halves of a chained pair sit at 0xFFFFFFFF and the low half wraps, the high half wraps too, and both overflow flags are set at the same clock edge.
- R9: The enabled cycle counter adds one per cycle across 64 bits. With the long mode set, its flag sets on the wrap of all 64 bits. With the long mode clear, it sets when the low 32 bits wrap.
- R10: Reading index NUM_CNT returns all 64 cycle-counter bits. Reading a general index returns its 32 bits, zero-extended. A write loads the addressed counter, keeping the low 32 bits for a general counter, and takes priority over any increment in that cycle.
- R11: The interrupt output is high exactly when some overflow flag is set whose interrupt-enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_strobe_i | input | NUM_EVT | Per-cycle hardware event strobes |
| sw_inc_i | input | NUM_CNT | Software increment mask, one bit per general counter |
| glb_en_i | input | 1 | Global counting enable |
| long_cyc_i | input | 1 | Cycle counter overflow at bit 63 (1) or bit 31 (0) |
| cnt_en_i | input | NUM_CNT+1 | Per-counter enable; top bit is the cycle counter |
| evt_sel_i | input | NUM_CNT*10 | Packed 10-bit type code per general counter |
| wr_en_i | input | 1 | Counter write strobe |
| wr_idx_i | input | IDX_W | Counter index to write |
| wr_data_i | input | 64 | Write data |
| rd_idx_i | input | IDX_W | Counter index to read |
| rd_data_o | output | 64 | Read data, combinational from rd_idx_i |
| ovf_clr_i | input | NUM_CNT+1 | Write-one-to-clear overflow mask |
| irq_en_i | input | NUM_CNT+1 | Interrupt enable per overflow flag |
| ovf_o | output | NUM_CNT+1 | Sticky overflow flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a counter changes only through a write on the port or an increment. They also assume that an increment adds at most two, an event plus a chain, so a flag can only rise when the counter was at least 0xFFFFFFFE one cycle before. They further assume that the write index names one counter at a time. The stimulus keeps to these limits: inputs change only at the falling edge, each write is a single-cycle pulse with a valid index, and type codes are always either a defined code or a value that counts nothing (0x3FF).

// File: rtl/chain_cnt_pkg.sv
package chain_cnt_pkg;
   localparam int EVT_W = 10;
   localparam logic [EVT_W-1:0] CODE_SWINC = 10'h000;
   localparam logic [EVT_W-1:0] CODE_CHAIN = 10'h01E;

   // True when counter idx may feed a chain event into idx+1
   function automatic bit can_chain(input int idx, input int num_cnt);
      return (idx >= 0) && (idx % 2 == 0) && (idx + 1 < num_cnt);
   endfunction
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    inc_i,
   input  logic          ld_i,
   input  logic [CW-1:0] ld_val_i,
   output logic [CW-1:0] cnt_o,
   output logic          wrap_o
);
   logic [CW-1:0] cnt_q;
   logic [CW:0]   sum;

   if (CW < 2) begin : g_bad_cw
      $error("evt_cnt_slice: CW must be at least 2");
   end

   assign sum    = {1'b0, cnt_q} + {{(CW-1){1'b0}}, inc_i};
   // a load replaces the value, so no wrap is reported that cycle
   assign wrap_o = sum[CW] & ~ld_i;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (ld_i) cnt_q <= ld_val_i;
      else           cnt_q <= sum[CW-1:0];
   end
endmodule

// File: rtl/cyc_cnt_unit.sv
module cyc_cnt_unit #(
   parameter int CW      = 64,
   parameter int SHORT_W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          long_i,
   input  logic          ld_i,
   input  logic [CW-1:0] ld_val_i,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);
   logic [CW-1:0] cnt_q;
   logic          full_long, full_short;

   if (SHORT_W >= CW || SHORT_W < 1) begin : g_bad_w
      $error("cyc_cnt_unit: SHORT_W must lie in 1..CW-1");
   end

   assign full_long  = &cnt_q;
   assign full_short = &cnt_q[SHORT_W-1:0];
   assign ovf_o      = run_i & ~ld_i & (long_i ? full_long : full_short);
   assign cnt_o      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_i)  cnt_q <= ld_val_i;
      else if (run_i) cnt_q <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/chain_cnt_bank.sv
module chain_cnt_bank
   import chain_cnt_pkg::*;
#(
   parameter  int NUM_CNT = 5,
   parameter  int NUM_EVT = 8,
   parameter  int CNT_W   = 32,
   parameter  int CYC_W   = 64,
   localparam int IDX_W   = $clog2(NUM_CNT + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EVT-1:0]       evt_strobe_i,
   input  logic [NUM_CNT-1:0]       sw_inc_i,
   input  logic                     glb_en_i,
   input  logic                     long_cyc_i,
   input  logic [NUM_CNT:0]         cnt_en_i,
   input  logic [NUM_CNT*EVT_W-1:0] evt_sel_i,
   input  logic                     wr_en_i,
   input  logic [IDX_W-1:0]         wr_idx_i,
   input  logic [CYC_W-1:0]         wr_data_i,
   input  logic [IDX_W-1:0]         rd_idx_i,
   output logic [CYC_W-1:0]         rd_data_o,
   input  logic [NUM_CNT:0]         ovf_clr_i,
   input  logic [NUM_CNT:0]         irq_en_i,
   output logic [NUM_CNT:0]         ovf_o,
   output logic                     irq_o
);
   if (NUM_CNT < 2 || NUM_CNT > 30) begin : g_bad_cnt
      $error("chain_cnt_bank: NUM_CNT must lie in 2..30");
   end
   if (NUM_EVT < 1 || NUM_EVT + 1 > int'(CODE_CHAIN)) begin : g_bad_evt
      $error("chain_cnt_bank: event codes would collide with the chain code");
   end
   if (CNT_W >= CYC_W) begin : g_bad_w
      $error("chain_cnt_bank: CNT_W must be narrower than CYC_W");
   end

   logic [NUM_CNT*CNT_W-1:0] cnt_flat;
   logic [CYC_W-1:0]         cyc_q;
   logic [NUM_CNT:0]         ovf_set;
   logic [NUM_CNT:0]         ovf_q;
   logic                     wrap [NUM_CNT];

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic [EVT_W-1:0] sel;
      logic             en, hw_hit, base_hit, chain_src, chain_hit, ld;
      logic [1:0]       inc;

      assign sel = evt_sel_i[i*EVT_W +: EVT_W];
      assign en  = glb_en_i & cnt_en_i[i];

      always_comb begin
         hw_hit = 1'b0;
         for (int k = 0; k < NUM_EVT; k++) begin
            if (sel == EVT_W'(k + 1)) hw_hit = evt_strobe_i[k];
         end
      end

      if ((i % 2 == 1) && can_chain(i - 1, NUM_CNT)) begin : g_link
         assign chain_src = wrap[i-1];
      end else begin : g_nolink
         assign chain_src = 1'b0;
      end

      assign base_hit  = (sel == CODE_SWINC) ? sw_inc_i[i] : hw_hit;
      assign chain_hit = (sel == CODE_CHAIN) & chain_src;
      assign inc       = {1'b0, en & base_hit} + {1'b0, en & chain_hit};
      assign ld        = wr_en_i && (wr_idx_i == IDX_W'(i));

      evt_cnt_slice #(.CW(CNT_W)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_i    (inc),
         .ld_i     (ld),
         .ld_val_i (wr_data_i[CNT_W-1:0]),
         .cnt_o    (cnt_flat[i*CNT_W +: CNT_W]),
         .wrap_o   (wrap[i])
      );

      assign ovf_set[i] = wrap[i];
   end

   cyc_cnt_unit #(.CW(CYC_W), .SHORT_W(CNT_W)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (glb_en_i & cnt_en_i[NUM_CNT]),
      .long_i   (long_cyc_i),
      .ld_i     (wr_en_i && (wr_idx_i == IDX_W'(NUM_CNT))),
      .ld_val_i (wr_data_i),
      .cnt_o    (cyc_q),
      .ovf_o    (ovf_set[NUM_CNT])
   );

   // sticky flags: a new overflow beats a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= (ovf_q & ~ovf_clr_i) | ovf_set;
   end

   assign ovf_o = ovf_q;
   assign irq_o = |(ovf_q & irq_en_i);

   always_comb begin
      rd_data_o = '0;
      if (rd_idx_i == IDX_W'(NUM_CNT)) begin
         rd_data_o = cyc_q;
      end else begin
         for (int k = 0; k < NUM_CNT; k++) begin
            if (rd_idx_i == IDX_W'(k)) rd_data_o = CYC_W'(cnt_flat[k*CNT_W +: CNT_W]);
         end
      end
   end
endmodule

// File: rtl/chain_cnt_bank_chk.sv
module chain_cnt_bank_chk #(
   parameter int NUM_CNT = 5,
   parameter int CNT_W   = 32,
   parameter int CYC_W   = 64,
   parameter int IDX_W   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     glb_en_i,
   input logic [NUM_CNT:0]         cnt_en_i,
   input logic                     wr_en_i,
   input logic [IDX_W-1:0]         wr_idx_i,
   input logic [NUM_CNT:0]         ovf_clr_i,
   input logic [NUM_CNT:0]         ovf_o,
   input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   input logic [CYC_W-1:0]         cyc_q
);
   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en_i && !wr_en_i) |=> ($stable(cnt_flat) && $stable(cyc_q)));

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_gen
      p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!cnt_en_i[i] && !(wr_en_i && wr_idx_i == IDX_W'(i)))
            |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

      p_ovf_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_o[i]) |-> ($past(cnt_flat[i*CNT_W +: CNT_W]) >= {{(CNT_W-1){1'b1}}, 1'b0}));
   end

   for (genvar i = 0; i <= NUM_CNT; i++) begin : g_all
      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf_o[i] && !ovf_clr_i[i]) |=> ovf_o[i]);
   end

   p_cyc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en_i && cnt_en_i[NUM_CNT] && !(wr_en_i && wr_idx_i == IDX_W'(NUM_CNT)))
         |=> (cyc_q == $past(cyc_q) + {{(CYC_W-1){1'b0}}, 1'b1}));

   p_cyc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en_i[NUM_CNT] && !(wr_en_i && wr_idx_i == IDX_W'(NUM_CNT))) |=> $stable(cyc_q));
endmodule

bind chain_cnt_bank chain_cnt_bank_chk #(
   .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CYC_W(CYC_W), .IDX_W(IDX_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .glb_en_i  (glb_en_i),
   .cnt_en_i  (cnt_en_i),
   .wr_en_i   (wr_en_i),
   .wr_idx_i  (wr_idx_i),
   .ovf_clr_i (ovf_clr_i),
   .ovf_o     (ovf_o),
   .cnt_flat  (cnt_flat),
   .cyc_q     (cyc_q)
);

// File: tb/chain_cnt_bank_tb.sv
module chain_cnt_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 5;
   localparam int NE = 8;
   localparam int IW = 3;
   localparam logic [9:0] T_SW = 10'h000;
   localparam logic [9:0] T_CH = 10'h01E;
   localparam logic [9:0] T_NONE = 10'h3FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt_strobe = '0;
   logic [NC-1:0] sw_inc = '0;
   logic          glb_en = 1'b0;
   logic          long_cyc = 1'b0;
   logic [NC:0]   cnt_en = '0;
   logic [NC*10-1:0] evt_sel = {NC{T_NONE}};
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [63:0]   wr_data = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [63:0]   rd_data;
   logic [NC:0]   ovf_clr = '0;
   logic [NC:0]   irq_en = '0;
   logic [NC:0]   ovf;
   logic          irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chain_cnt_bank #(.NUM_CNT(NC), .NUM_EVT(NE)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_strobe_i(evt_strobe), .sw_inc_i(sw_inc),
      .glb_en_i(glb_en), .long_cyc_i(long_cyc), .cnt_en_i(cnt_en), .evt_sel_i(evt_sel),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .rd_idx_i(rd_idx),
      .rd_data_o(rd_data), .ovf_clr_i(ovf_clr), .irq_en_i(irq_en), .ovf_o(ovf), .irq_o(irq)
   );

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic check_cnt(input string req, input int idx, input logic [63:0] exp);
      rd_idx = IW'(idx);
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic set_sel(input int i, input logic [9:0] code);
      evt_sel[i*10 +: 10] = code;
   endtask

   task automatic wr_cnt(input int idx, input logic [63:0] val);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = val;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic clr_ovf(input logic [NC:0] m);
      ovf_clr = m;
      step(1);
      ovf_clr = '0;
   endtask

   task automatic t_reset;
      for (int i = 0; i <= NC; i++) check_cnt("R10 reset value", i, 64'd0);
      check("R5 reset flags", 64'(ovf), 64'd0);
      check("R11 reset irq", 64'(irq), 64'd0);
   endtask

   task automatic t_basic;
      set_sel(0, 10'd1); set_sel(1, 10'd2);
      cnt_en = 6'b000011; glb_en = 1'b1;
      evt_strobe = 8'b01; step(1);
      evt_strobe = 8'b11; step(1);
      evt_strobe = 8'b00; step(1);
      evt_strobe = 8'b11; step(1);
      evt_strobe = '0;
      check_cnt("R1 strobe0 count", 0, 64'd3);
      check_cnt("R1 strobe1 count", 1, 64'd2);
   endtask

   task automatic t_gate;
      glb_en = 1'b0; cnt_en = 6'b100011;
      evt_strobe = 8'b11; sw_inc = '1; step(2);
      evt_strobe = '0; sw_inc = '0; cnt_en = 6'b000011;
      check_cnt("R2 counter0 held", 0, 64'd3);
      check_cnt("R2 counter1 held", 1, 64'd2);
      check_cnt("R2 cycle held", NC, 64'd0);
   endtask

   task automatic t_enable;
      glb_en = 1'b1; set_sel(2, T_SW); cnt_en = 6'b000010;
      sw_inc = 5'b00100; evt_strobe = 8'b01; step(1);
      sw_inc = '0; evt_strobe = '0;
      check_cnt("R3 disabled swinc", 2, 64'd0);
      check_cnt("R3 disabled event", 0, 64'd3);
   endtask

   task automatic t_swinc;
      set_sel(3, T_SW); cnt_en = 6'b001100;
      sw_inc = 5'b00100; evt_strobe = 8'hFF; step(1);
      sw_inc = 5'b01100; step(1);
      sw_inc = '0; evt_strobe = '0;
      check_cnt("R4 swinc counter2", 2, 64'd2);
      check_cnt("R4 swinc counter3", 3, 64'd1);
   endtask

   task automatic t_chain;
      cnt_en = 6'b000011; set_sel(0, 10'd1); set_sel(1, T_CH); irq_en = 6'b000010;
      wr_cnt(0, 64'hFFFF_FFFF); wr_cnt(1, 64'd5);
      evt_strobe = 8'b01; step(1); evt_strobe = '0;
      check_cnt("R5 low wraps", 0, 64'd0);
      check_cnt("R6 chain counted", 1, 64'd6);
      check("R5 low flag only", 64'(ovf), 64'h01);
      check("R11 irq masked", 64'(irq), 64'd0);
      step(2);
      check("R5 flag sticky", 64'(ovf), 64'h01);
      clr_ovf(6'b000001);
      check("R5 flag cleared", 64'(ovf), 64'h00);
   endtask

   task automatic t_chain_gate;
      cnt_en = 6'b000001;
      wr_cnt(0, 64'hFFFF_FFFF);
      evt_strobe = 8'b01; step(1); evt_strobe = '0;
      check_cnt("R6 disabled partner", 1, 64'd6);
      cnt_en = 6'b000011; set_sel(1, 10'd1);
      wr_cnt(0, 64'hFFFF_FFFF);
      evt_strobe = 8'b01; step(1); evt_strobe = '0;
      check_cnt("R6 wrong type ignores chain", 1, 64'd7);
      ovf_clr = 6'b000001; evt_strobe = 8'b01;
      wr_cnt(0, 64'hFFFF_FFFF);
      step(1); evt_strobe = '0; ovf_clr = 6'b000001;
      step(1); ovf_clr = '0;
      clr_ovf('1);
      check("R5 cleared after gate", 64'(ovf), 64'h00);
   endtask

   task automatic t_setwins;
      cnt_en = 6'b000001;
      wr_cnt(0, 64'hFFFF_FFFF);
      evt_strobe = 8'b01; ovf_clr = 6'b000001; step(1);
      evt_strobe = '0; ovf_clr = '0;
      check("R5 set beats clear", 64'(ovf[0]), 64'd1);
      clr_ovf('1);
   endtask

   task automatic t_both;
      cnt_en = 6'b000011; set_sel(1, T_CH);
      wr_cnt(0, 64'hFFFF_FFFF); wr_cnt(1, 64'hFFFF_FFFF);
      evt_strobe = 8'b01; step(1); evt_strobe = '0;
      check_cnt("R8 high wraps", 1, 64'd0);
      check("R8 both flags", 64'(ovf), 64'h03);
      check("R11 irq on enabled flag", 64'(irq), 64'd1);
      clr_ovf(6'b000011);
      check("R11 irq drops", 64'(irq), 64'd0);
   endtask

   task automatic t_last;
      set_sel(3, T_CH); set_sel(4, 10'd1); cnt_en = 6'b000000;
      wr_cnt(3, 64'd10); wr_cnt(4, 64'hFFFF_FFFF); wr_cnt(NC, 64'd0);
      cnt_en = 6'b111000; evt_strobe = 8'b01; step(1);
      evt_strobe = '0; cnt_en = '0;
      check_cnt("R7 last even wraps", 4, 64'd0);
      check_cnt("R7 odd neighbour untouched", 3, 64'd10);
      check_cnt("R7 cycle plus one", NC, 64'd1);
      check("R7 only own flag", 64'(ovf), 64'h10);
      clr_ovf('1);
   endtask

   task automatic t_cyc;
      long_cyc = 1'b0;
      wr_cnt(NC, 64'h0000_0000_FFFF_FFFE);
      cnt_en = 6'b100000; step(2); cnt_en = '0;
      check_cnt("R9 short carry value", NC, 64'h0000_0001_0000_0000);
      check("R9 short overflow", 64'(ovf[NC]), 64'd1);
      clr_ovf('1);
      long_cyc = 1'b1;
      wr_cnt(NC, 64'h0000_0000_FFFF_FFFF);
      cnt_en = 6'b100000; step(1); cnt_en = '0;
      check_cnt("R9 long carry value", NC, 64'h0000_0001_0000_0000);
      check("R9 long no flag at bit31", 64'(ovf[NC]), 64'd0);
      wr_cnt(NC, 64'hFFFF_FFFF_FFFF_FFFF);
      cnt_en = 6'b100000; step(1); cnt_en = '0;
      check_cnt("R9 long wrap value", NC, 64'd0);
      check("R9 long overflow", 64'(ovf[NC]), 64'd1);
      clr_ovf('1); long_cyc = 1'b0;
   endtask

   task automatic t_rw;
      wr_cnt(2, 64'hAAAA_BBBB_1234_5678);
      check_cnt("R10 general truncated", 2, 64'h0000_0000_1234_5678);
      wr_cnt(NC, 64'h1234_5678_9ABC_DEF0);
      check_cnt("R10 cycle full width", NC, 64'h1234_5678_9ABC_DEF0);
      set_sel(2, T_SW); cnt_en = 6'b000100; sw_inc = 5'b00100;
      wr_cnt(2, 64'h50);
      sw_inc = '0; cnt_en = '0;
      check_cnt("R10 write beats increment", 2, 64'h50);
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_basic();
      t_gate();
      t_enable();
      t_swinc();
      t_chain();
      t_chain_gate();
      t_setwins();
      t_both();
      t_last();
      t_cyc();
      t_rw();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule